// File: doc/BRIEF.md
# Register Save/Restore Sequencer with Stack Guard

This block executes multi-register save and restore instructions for function entry and exit code. A save instruction writes the selected registers to the stack through a pre-decremented stack pointer, one word per accepted memory request. A restore instruction reads them back in mirror order. The instruction selects a contiguous register range by a 6-bit upper and a 6-bit lower bound, plus flags that add the return-address register, the global-pointer register and a guard word.

The guard word is the XOR of a secret value and a stack pointer, so two uses of the same save/restore sequence at different stack depths produce different words. On a restore the guard is read first and compared. A mismatch raises a sticky fault, and the restore stops before any register is written. A global enable input switches guard handling off entirely. The registers, the memory port and the stack pointer are external. The block only sequences the transfers between them.

Top module: `regsave_seq`

## Requirements
- R1: A save writes (mem_req_write=1) in the order: return-address register (register LINK_REG, default 1) if flagged, global pointer (register GP_REG, default 3) if flagged, registers lower bound up to upper bound, then the guard word if active. Each word goes to the address 4 below the previous stack pointer, and the first word goes to sp_in-4.
- R2: Range registers move only when cmd_hi >= cmd_lo. With cmd_hi < cmd_lo no range register is read or written.
- R3: A restore reads (mem_req_write=0) from sp_in upward in steps of 4, in the order: guard word if active, registers upper bound down to lower bound, global pointer, return-address register. Each read word is written to its register through rf_we/rf_waddr/rf_wdata.
- R4: The guard word written by a save equals guard_secret XOR sp_in. A restore of N words expects guard_secret XOR (sp_in + 4*N), which is the save's starting pointer.
- R5: On a guard mismatch the restore asserts fault, writes no register, issues no further request, and finishes with sp_out equal to its sp_in.
- R6: With guard_enable=0 the cmd_guard flag has no effect: no guard word is written or read, and fault stays low.
- R7: fault stays high after the failing restore until the next instruction is accepted, and then clears. fault_data holds the mismatching word that was read.
- R8: A memory request keeps its address, direction and data stable until mem_req_ready. At most one read is outstanding. cmd_ready is high only while the block is idle.
- R9: busy is high from the cycle after acceptance through the single-cycle done pulse. At done, sp_out is sp_in-4*N for a save and sp_in+4*N for a restore.
- R10: An instruction that selects no word issues no memory request, pulses done, and reports sp_out = sp_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Block idle, instruction taken this cycle |
| cmd_is_load | input | 1 | 1 = restore, 0 = save |
| cmd_hi | input | 6 | Upper register bound |
| cmd_lo | input | 6 | Lower register bound |
| cmd_link | input | 1 | Include return-address register |
| cmd_gp | input | 1 | Include global-pointer register |
| cmd_guard | input | 1 | Include guard word |
| sp_in | input | 32 | Stack pointer at acceptance |
| guard_secret | input | 32 | Secret XORed into the guard word |
| guard_enable | input | 1 | Global guard enable |
| rf_raddr | output | 6 | Register read index |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 6 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Final stack pointer, valid at done |
| fault | output | 1 | Sticky guard mismatch |
| fault_data | output | 32 | Word read at the mismatch |

## Verification
The bench targets inverted bounds and the single-register range. An off-by-one in the range test would move a register that should stay put, or drop the only one. It targets a guard flag set while guard_enable is low, where a design that ignored the enable would push an extra word and shift sp_out by 4. It corrupts the stored guard, and separately changes the secret, before a restore. A design that checked the guard too late or wrote registers on a mismatch would overwrite clobbered registers and lose the sticky fault. Random memory back-pressure checks that the transfer order and addresses hold across stalls.

// File: rtl/regsave_pkg.sv
package regsave_pkg;
  localparam int XLEN       = 32;
  localparam int IDX_W      = 6;
  localparam int WORD_BYTES = XLEN / 8;
  localparam int CNT_W      = IDX_W + 2;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {ST_LINK, ST_GP, ST_RANGE, ST_GUARD, ST_END} step_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} phase_e;

  typedef struct packed {
    step_e step;
    idx_t  idx;
  } pos_t;

  typedef struct packed {
    logic is_load;
    logic lnk;
    logic gp;
    logic grd;
    idx_t hi;
    idx_t lo;
  } cmd_t;

  function automatic pos_t at_pos(step_e s, idx_t i);
    pos_t p;
    p.step = s;
    p.idx  = i;
    return p;
  endfunction

  // first save position at or after s
  function automatic pos_t store_from(step_e s, cmd_t c);
    if (s == ST_LINK && c.lnk) return at_pos(ST_LINK, c.lo);
    if ((s == ST_LINK || s == ST_GP) && c.gp) return at_pos(ST_GP, c.lo);
    if (s != ST_GUARD && s != ST_END && c.hi >= c.lo) return at_pos(ST_RANGE, c.lo);
    if (s != ST_END && c.grd) return at_pos(ST_GUARD, c.lo);
    return at_pos(ST_END, c.lo);
  endfunction

  // first restore position at or after s (restore order: guard, range, gp, link)
  function automatic pos_t load_from(step_e s, cmd_t c);
    if (s == ST_GUARD && c.grd) return at_pos(ST_GUARD, c.hi);
    if ((s == ST_GUARD || s == ST_RANGE) && c.hi >= c.lo) return at_pos(ST_RANGE, c.hi);
    if (s != ST_LINK && s != ST_END && c.gp) return at_pos(ST_GP, c.hi);
    if (s != ST_END && c.lnk) return at_pos(ST_LINK, c.hi);
    return at_pos(ST_END, c.hi);
  endfunction

  function automatic pos_t store_next(pos_t p, cmd_t c);
    case (p.step)
      ST_LINK:  return store_from(ST_GP, c);
      ST_GP:    return store_from(ST_RANGE, c);
      ST_RANGE: return (p.idx != c.hi) ? at_pos(ST_RANGE, p.idx + idx_t'(1))
                                       : store_from(ST_GUARD, c);
      ST_GUARD: return at_pos(ST_END, c.lo);
      default:  return p;
    endcase
  endfunction

  function automatic pos_t load_next(pos_t p, cmd_t c);
    case (p.step)
      ST_GUARD: return load_from(ST_RANGE, c);
      ST_RANGE: return (p.idx != c.lo) ? at_pos(ST_RANGE, p.idx - idx_t'(1))
                                       : load_from(ST_GP, c);
      ST_GP:    return load_from(ST_LINK, c);
      ST_LINK:  return at_pos(ST_END, c.hi);
      default:  return p;
    endcase
  endfunction

  function automatic cnt_t word_count(cmd_t c);
    cnt_t n;
    n = '0;
    if (c.hi >= c.lo) n = cnt_t'(c.hi) - cnt_t'(c.lo) + cnt_t'(1);
    n = n + cnt_t'(c.lnk) + cnt_t'(c.gp) + cnt_t'(c.grd);
    return n;
  endfunction

  function automatic word_t span_bytes(cnt_t n);
    return word_t'(n) * word_t'(WORD_BYTES);
  endfunction

  function automatic word_t guard_of(word_t secret, word_t sp);
    return secret ^ sp;
  endfunction
endpackage

// File: rtl/regsave_walker.sv
module regsave_walker
  import regsave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_t start_cmd,
  input  logic advance,
  output pos_t pos,
  output logic last
);
  cmd_t cmd_q;
  pos_t pos_q;
  pos_t first_pos;
  pos_t next_pos;

  always_comb begin
    first_pos = start_cmd.is_load ? load_from(ST_GUARD, start_cmd)
                                  : store_from(ST_LINK, start_cmd);
    next_pos  = cmd_q.is_load ? load_next(pos_q, cmd_q) : store_next(pos_q, cmd_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      pos_q <= at_pos(ST_END, '0);
    end else if (start) begin
      cmd_q <= start_cmd;
      pos_q <= first_pos;
    end else if (advance) begin
      pos_q <= next_pos;
    end
  end

  assign pos  = pos_q;
  assign last = (next_pos.step == ST_END);

  // R2: a range position only exists inside a non-empty window
  a_r2_range_window: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q.step == ST_RANGE |-> (cmd_q.hi >= cmd_q.lo &&
                                pos_q.idx >= cmd_q.lo && pos_q.idx <= cmd_q.hi));
endmodule

// File: rtl/regsave_guard.sv
module regsave_guard
  import regsave_pkg::*;
(
  input  word_t secret,
  input  word_t sp_base,
  input  cnt_t  words,
  input  logic  is_load,
  input  word_t expect_word,
  input  word_t loaded,
  output word_t guard_word,
  output logic  mismatch
);
  word_t origin;

  // a restore rebuilds the pointer the matching save started from
  assign origin     = is_load ? (sp_base + span_bytes(words)) : sp_base;
  assign guard_word = guard_of(secret, origin);
  assign mismatch   = (loaded != expect_word);
endmodule

// File: rtl/regsave_fault.sv
module regsave_fault
  import regsave_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  set,
  input  word_t bad_word,
  output logic  fault,
  output word_t fault_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      fault_data <= '0;
    end else if (clear) begin
      fault      <= 1'b0;
    end else if (set) begin
      fault      <= 1'b1;
      fault_data <= bad_word;
    end
  end

  // R7: sticky until the next accepted instruction
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clear |=> fault && $stable(fault_data));
  a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fault);
endmodule

// File: rtl/regsave_seq.sv
module regsave_seq
  import regsave_pkg::*;
#(
  parameter int LINK_REG = 1,
  parameter int GP_REG   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_is_load,
  input  logic [IDX_W-1:0] cmd_hi,
  input  logic [IDX_W-1:0] cmd_lo,
  input  logic             cmd_link,
  input  logic             cmd_gp,
  input  logic             cmd_guard,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  guard_secret,
  input  logic             guard_enable,
  output logic [IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]  rf_rdata,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [XLEN-1:0]  mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [XLEN-1:0]  mem_rsp_rdata,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  sp_out,
  output logic             fault,
  output logic [XLEN-1:0]  fault_data
);
  localparam word_t STEP_BYTES = word_t'(WORD_BYTES);
  localparam idx_t  LINK_IDX   = idx_t'(LINK_REG);
  localparam idx_t  GP_IDX     = idx_t'(GP_REG);

  phase_e state_q, state_d;
  logic   accept;
  cmd_t   live_cmd;
  cnt_t   live_words;
  cnt_t   words_q;
  logic   is_load_q;
  logic   grd_q;
  word_t  sp_q;
  word_t  expect_q;
  word_t  guard_word;
  logic   guard_cmp;
  pos_t   pos;
  logic   last;
  logic   step_done;
  logic   rsp_here;
  logic   guard_bad;
  logic   reg_step;
  idx_t   reg_sel;

  // instruction as seen at acceptance, guard flag gated by the enable
  assign accept         = cmd_valid && cmd_ready;
  assign live_cmd.is_load = cmd_is_load;
  assign live_cmd.lnk   = cmd_link;
  assign live_cmd.gp    = cmd_gp;
  assign live_cmd.grd   = cmd_guard && guard_enable;
  assign live_cmd.hi    = cmd_hi;
  assign live_cmd.lo    = cmd_lo;
  assign live_words     = word_count(live_cmd);

  regsave_walker u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_cmd (live_cmd),
    .advance   (step_done),
    .pos       (pos),
    .last      (last)
  );

  regsave_guard u_guard (
    .secret      (guard_secret),
    .sp_base     (sp_in),
    .words       (live_words),
    .is_load     (cmd_is_load),
    .expect_word (expect_q),
    .loaded      (mem_rsp_rdata),
    .guard_word  (guard_word),
    .mismatch    (guard_cmp)
  );

  // named internal events
  assign rsp_here  = (state_q == S_WAIT) && mem_rsp_valid;
  assign guard_bad = rsp_here && (pos.step == ST_GUARD) && guard_cmp;
  assign step_done = ((state_q == S_ISSUE) && mem_req_ready && !is_load_q) ||
                     (rsp_here && !guard_bad);
  assign reg_step  = (pos.step == ST_LINK) || (pos.step == ST_GP) || (pos.step == ST_RANGE);

  always_comb begin
    case (pos.step)
      ST_LINK:  reg_sel = LINK_IDX;
      ST_GP:    reg_sel = GP_IDX;
      ST_RANGE: reg_sel = pos.idx;
      default:  reg_sel = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept) state_d = (live_words == '0) ? S_DONE : S_ISSUE;
      S_ISSUE: if (mem_req_ready) begin
                 if (is_load_q)  state_d = S_WAIT;
                 else if (last)  state_d = S_DONE;
               end
      S_WAIT:  if (mem_rsp_valid) begin
                 if (guard_bad || last) state_d = S_DONE;
                 else                   state_d = S_ISSUE;
               end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      words_q   <= '0;
      is_load_q <= 1'b0;
      grd_q     <= 1'b0;
      sp_q      <= '0;
      expect_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        words_q   <= live_words;
        is_load_q <= cmd_is_load;
        grd_q     <= live_cmd.grd;
        sp_q      <= sp_in;
        expect_q  <= guard_word;
      end else if (step_done) begin
        sp_q <= is_load_q ? (sp_q + STEP_BYTES) : (sp_q - STEP_BYTES);
      end
    end
  end

  // memory port: save pre-decrements, restore reads at the pointer
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_write = !is_load_q;
  assign mem_req_addr  = is_load_q ? sp_q : (sp_q - STEP_BYTES);
  assign mem_req_wdata = (pos.step == ST_GUARD) ? expect_q : (reg_step ? rf_rdata : '0);

  assign rf_raddr = reg_sel;
  assign rf_we    = rsp_here && is_load_q && reg_step;
  assign rf_waddr = reg_sel;
  assign rf_wdata = mem_rsp_rdata;

  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign sp_out    = sp_q;

  regsave_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .set        (guard_bad),
    .bad_word   (mem_rsp_rdata),
    .fault      (fault),
    .fault_data (fault_data)
  );

  // R8: a stalled request holds still
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
                                        $stable(mem_req_write));
  // R1: an accepted save write lands one word below the old pointer
  a_r1_store_descends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> sp_out == $past(mem_req_addr));
  // R5: a mismatching guard never reaches the register file
  a_r5_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    guard_bad |-> !rf_we);
  // R6: the walker visits the guard step only when it was enabled at accept
  a_r6_guard_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pos.step == ST_GUARD |-> grd_q);
  // R3: a guarded restore starts with the guard word
  a_r3_guard_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && is_load_q && grd_q |-> pos.step == ST_GUARD);
  // R9: done is one cycle, then the block is idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R10: an empty instruction never touches memory
  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy && words_q == '0 |-> !mem_req_valid);
endmodule

// File: tb/test_regsave_seq.sv
module test_regsave_seq;
  import regsave_pkg::*;

  localparam int LINK_R = 1;
  localparam int GP_R   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_is_load, cmd_link, cmd_gp, cmd_guard, guard_enable;
  logic [IDX_W-1:0] cmd_hi, cmd_lo, rf_raddr, rf_waddr;
  logic [XLEN-1:0] sp_in, guard_secret, rf_rdata, rf_wdata, mem_req_addr, mem_req_wdata;
  logic [XLEN-1:0] mem_rsp_rdata, sp_out, fault_data;
  logic rf_we, mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid, busy, done, fault;

  regsave_seq i_regsave_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_load(cmd_is_load), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .cmd_link(cmd_link),
    .cmd_gp(cmd_gp), .cmd_guard(cmd_guard), .sp_in(sp_in), .guard_secret(guard_secret),
    .guard_enable(guard_enable), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .busy(busy), .done(done), .sp_out(sp_out), .fault(fault), .fault_data(fault_data)
  );

  word_t regs [64];
  word_t mem  [256];
  word_t log_addr [128];
  word_t log_data [128];
  logic  log_wr   [128];
  int    log_n;
  int    wr_n;
  int    vecs  = 0;
  int    fails = 0;

  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[9:2]];
      end
      if (log_n < 128) begin
        log_addr[log_n] <= mem_req_addr;
        log_data[log_n] <= mem_req_wdata;
        log_wr[log_n]   <= mem_req_write;
      end
      log_n <= log_n + 1;
    end
    if (rst_n && rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      wr_n <= wr_n + 1;
    end
  end

  always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

  task automatic check(input string req, input string what, input word_t act, input word_t exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual %h expected %h", 32'd0, 32'd1);
    finish_run();
  end

  task automatic run_cmd(input logic ld, input logic lnk, input logic gp, input logic grd,
                         input logic en, input idx_t hi, input idx_t lo, input word_t sp,
                         input word_t secret, output word_t sp_res, output logic flt,
                         output word_t fdat);
    int cyc;
    @(negedge clk);
    cmd_is_load = ld; cmd_link = lnk; cmd_gp = gp; cmd_guard = grd; guard_enable = en;
    cmd_hi = hi; cmd_lo = lo; sp_in = sp; guard_secret = secret;
    log_n = 0; wr_n = 0;
    check("R8", "cmd_ready while idle", word_t'(cmd_ready), 32'd1);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!done) check("R8", "cmd_ready while busy", word_t'(cmd_ready), 32'd0);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check("R9", "done reached", word_t'(done), 32'd1);
    check("R9", "busy at done", word_t'(busy), 32'd1);
    sp_res = sp_out; flt = fault; fdat = fault_data;
  endtask

  // tamper: 0 none, 1 corrupt stored guard, 2 restore with a different secret
  task automatic do_pair(input logic lnk, input logic gp, input logic grd, input logic en,
                         input idx_t hi, input idx_t lo, input word_t sp0, input word_t secret,
                         input int tamper, input logic prev_fault);
    word_t exp_data [128];
    word_t snap [64];
    word_t clob [64];
    logic [63:0] touched;
    word_t sp_res, fdat, sp_fin, gword, cv;
    logic flt, geff;
    int n, t;
    geff = grd && en;
    if (!geff) t = 0; else t = tamper;
    for (int i = 0; i < 64; i++) begin regs[i] = $urandom; snap[i] = regs[i]; end
    n = 0; touched = '0;
    if (lnk) begin exp_data[n] = snap[LINK_R]; n++; touched[LINK_R] = 1'b1; end
    if (gp)  begin exp_data[n] = snap[GP_R];   n++; touched[GP_R] = 1'b1; end
    if (hi >= lo) for (int i = int'(lo); i <= int'(hi); i++) begin
      exp_data[n] = snap[i]; n++; touched[i] = 1'b1;
    end
    gword = secret ^ sp0;
    if (geff) begin exp_data[n] = gword; n++; end
    sp_fin = sp0 - word_t'(4 * n);

    run_cmd(1'b0, lnk, gp, grd, en, hi, lo, sp0, secret, sp_res, flt, fdat);
    check("R9", "save sp_out", sp_res, sp_fin);
    check(prev_fault ? "R7" : "R5", "fault after save", word_t'(flt), 32'd0);
    check((n == 0) ? "R10" : (grd && !en) ? "R6" : "R2", "save word count",
          word_t'(log_n), word_t'(n));
    for (int k = 0; k < n && k < log_n; k++) begin
      check("R1", "save address", log_addr[k], sp0 - word_t'(4 * (k + 1)));
      check("R1", "save data", log_data[k], exp_data[k]);
      check("R1", "save direction", word_t'(log_wr[k]), 32'd1);
    end
    if (geff && log_n == n && n > 0) check("R4", "stored guard", log_data[n-1], gword);

    for (int i = 0; i < 64; i++) begin clob[i] = ~snap[i]; regs[i] = clob[i]; end
    cv = gword;
    if (t == 1) begin cv = gword ^ 32'h0000_0001; mem[sp_fin[9:2]] = cv; end

    run_cmd(1'b1, lnk, gp, grd, en, hi, lo, sp_fin,
            (t == 2) ? (secret ^ 32'h0000_0010) : secret, sp_res, flt, fdat);
    if (t != 0) begin
      check("R5", "fault raised", word_t'(flt), 32'd1);
      check("R7", "fault_data", fdat, cv);
      check("R5", "register writes", word_t'(wr_n), 32'd0);
      check("R5", "reads issued", word_t'(log_n), 32'd1);
      check("R5", "sp_out on fault", sp_res, sp_fin);
      for (int i = 0; i < 64; i++) check("R5", "register untouched", regs[i], clob[i]);
      repeat (3) @(negedge clk);
      check("R7", "fault held", word_t'(fault), 32'd1);
      check("R7", "fault_data held", fault_data, cv);
    end else begin
      check(geff ? "R4" : "R6", "no fault on restore", word_t'(flt), 32'd0);
      check("R9", "restore sp_out", sp_res, sp0);
      check("R3", "restore word count", word_t'(log_n), word_t'(n));
      for (int k = 0; k < n && k < log_n; k++) begin
        check("R3", "restore address", log_addr[k], sp_fin + word_t'(4 * k));
        check("R3", "restore direction", word_t'(log_wr[k]), 32'd0);
      end
      for (int i = 0; i < 64; i++)
        check("R3", "register after restore", regs[i], touched[i] ? snap[i] : clob[i]);
    end
  endtask

  initial begin
    logic pf;
    void'($urandom(32'd20250331));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_load = 1'b0; cmd_link = 1'b0; cmd_gp = 1'b0;
    cmd_guard = 1'b0; guard_enable = 1'b0; cmd_hi = '0; cmd_lo = '0; sp_in = '0;
    guard_secret = '0; log_n = 0; wr_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) regs[i] = '0;
    repeat (4) @(negedge clk);
    check("R9", "reset busy", word_t'(busy), 32'd0);
    check("R9", "reset done", word_t'(done), 32'd0);
    check("R7", "reset fault", word_t'(fault), 32'd0);
    check("R8", "reset cmd_ready", word_t'(cmd_ready), 32'd1);
    check("R8", "reset mem_req_valid", word_t'(mem_req_valid), 32'd0);
    rst_n = 1'b1;

    // directed corners
    do_pair(1, 1, 1, 1, 6'd63, 6'd0, 32'h300, 32'hC0FF_EE11, 0, 0);  // full range
    do_pair(0, 0, 0, 1, 6'd5,  6'd5, 32'h280, 32'h1234_5678, 0, 0);  // single register, R2
    do_pair(0, 0, 0, 1, 6'd2,  6'd9, 32'h240, 32'h0BAD_F00D, 0, 0);  // empty, R10
    do_pair(0, 0, 1, 0, 6'd1,  6'd7, 32'h244, 32'h5555_AAAA, 0, 0);  // guard off and empty, R6
    do_pair(1, 0, 1, 0, 6'd7,  6'd4, 32'h2F0, 32'h7777_1111, 0, 0);  // guard off, R6
    do_pair(1, 1, 1, 1, 6'd12, 6'd8, 32'h2C0, 32'hDEAD_BEEF, 1, 0);  // corrupted guard
    do_pair(0, 1, 1, 1, 6'd20, 6'd15, 32'h2A0, 32'h0F0F_F0F0, 0, 1); // clears R7
    do_pair(1, 1, 1, 1, 6'd3,  6'd3, 32'h260, 32'h2468_ACE0, 2, 0);  // wrong secret, R4
    pf = 1'b1;

    for (int it = 0; it < 40; it++) begin
      logic l, g, d, e;
      int tm;
      l = 1'($urandom); g = 1'($urandom); d = 1'($urandom); e = ($urandom % 4) != 0;
      tm = (($urandom % 6) == 0) ? int'(1 + ($urandom % 2)) : 0;
      do_pair(l, g, d, e, idx_t'($urandom % 64), idx_t'($urandom % 64),
              32'h200 + word_t'(4 * ($urandom % 64)), $urandom, tm, pf);
      pf = d && e && (tm != 0);
    end
    finish_run();
  end
endmodule